// File: doc/BRIEF.md
# Privileged Control Register Access Unit

This block carries out the move operations between the general registers and two 16-bit side address spaces. One is a coprocessor space and the other is an I/O space. Each operation arrives as a single-cycle request. A request carries an operation kind, a space select, an address and a 64-bit write value.

The coprocessor space is split on its top address bit. Addresses below 0x8000 go to a small bank of control registers inside the block. Addresses from 0x8000 upward are sent out as a one-cycle strobe to external coprocessor units. The I/O space is also sent out as a strobe.

The block holds two control registers: the maskable-interrupt enable and the supervisor mode flag. It checks privilege on every request. A forbidden request raises a one-cycle illegal-instruction exception with a cause code and leaves all state unchanged. A system-entry pulse puts the block back into supervisor mode.

Top module: `ctlreg_access_unit`

## Requirements
- R1: After a synchronous active-high reset, `sup_mode` is 1 and `int_en` is 0. `rd_valid`, `exc_valid`, `cp_valid` and `io_valid` are all 0.
- R2: A coprocessor-space request (`op_space`=0) whose `op_addr[15]` is 1 is allowed in both modes. One cycle later it produces a single-cycle `cp_valid` with `cp_addr`=`op_addr[14:0]`, `cp_write`=1 for a write, and `cp_wdata`=`op_wdata`.
- R3: In supervisor mode, a coprocessor write (`op_kind`=1) to address 0x0000 loads `int_en` from `op_wdata[0]`, and a write to 0x0001 loads `sup_mode` from `op_wdata[0]`. The new value is visible after the same clock edge. A read (`op_kind`=0) of these addresses returns the register in bit 0 on `rd_data`, with `rd_valid`, one cycle later.
- R4: In user mode, a read or write to coprocessor addresses 0x0000–0x7FFF raises `exc_valid` with `exc_cause`=2'b01 one cycle later. It gives no `rd_valid` and no strobe, and leaves `int_en` and `sup_mode` unchanged.
- R5: An I/O-space request (`op_space`=1) in supervisor mode produces a single-cycle `io_valid` carrying the full address, the write flag and the data. In user mode it instead raises `exc_cause`=2'b10.
- R6: `op_kind`=2 sets `int_en` and `op_kind`=3 clears it, in supervisor mode only. In user mode these kinds trap with cause 2'b01 and leave `int_en` unchanged.
- R7: A read of any unimplemented control-register address below 0x8000 returns zero. A write to such an address changes nothing.
- R8: `sys_enter` sets `sup_mode` after the same edge. It takes priority over a concurrent write to the mode register.
- R9: A read that goes to the coprocessor upper half or to I/O returns, one cycle later, the value of `cp_rdata` or `io_rdata` sampled at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| op_kind | input | 2 | 0 read, 1 write, 2 interrupt enable, 3 interrupt disable |
| op_space | input | 1 | 0 coprocessor space, 1 I/O space |
| op_addr | input | 16 | Address within the selected space |
| op_wdata | input | 64 | Write value |
| sys_enter | input | 1 | System entry: return to supervisor mode |
| cp_rdata | input | 64 | Read value from external coprocessor units |
| io_rdata | input | 64 | Read value from I/O space |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| exc_valid | output | 1 | Illegal-instruction exception |
| exc_cause | output | 2 | 01 control register, 10 I/O |
| cp_valid | output | 1 | Coprocessor strobe |
| cp_write | output | 1 | Coprocessor strobe is a write |
| cp_addr | output | 15 | Offset within upper coprocessor half |
| cp_wdata | output | 64 | Coprocessor write value |
| io_valid | output | 1 | I/O strobe |
| io_write | output | 1 | I/O strobe is a write |
| io_addr | output | 16 | I/O address |
| io_wdata | output | 64 | I/O write value |
| int_en | output | 1 | Maskable interrupt enable |
| sup_mode | output | 1 | Supervisor mode flag |

## Verification
The bench stresses the 0x7FFF/0x8000 boundary in user mode. A design that decoded the split on the wrong bit would trap the first upper address or let the last control address through. It drops the block into user mode through a control-register write and then tries every privileged kind. A leaky check would show up as a changed `int_en`, a spurious strobe or the wrong cause code, and an I/O trap reported as a control-register trap is caught by the cause value. `sys_enter` is raised in the same cycle as a mode-clearing write, so a design that gave the write priority would stay in user mode. A long pseudo-random mix then follows the mode flag through many transitions, with the reference model compared on every cycle.

// File: rtl/crau_pkg.sv
package crau_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        OP_RD     = 2'd0,
        OP_WR     = 2'd1,
        OP_IE_ON  = 2'd2,
        OP_IE_OFF = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_CTRL = 2'd1,
        CAUSE_IO   = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_CREG   = 2'd1,
        TGT_COPROC = 2'd2,
        TGT_IO     = 2'd3
    } target_e;

    typedef struct packed {
        logic    fault;
        cause_e  cause;
        target_e tgt;
        logic    is_write;
        logic    ie_set;
        logic    ie_clr;
    } decode_t;

    // Classify one request against the current privilege level.
    function automatic decode_t classify(input logic valid, input op_kind_e kind,
                                         input logic space_io, input logic addr_hi,
                                         input logic sup);
        decode_t d;
        d          = '0;
        d.cause    = CAUSE_NONE;
        d.tgt      = TGT_NONE;
        if (valid) begin
            case (kind)
                OP_IE_ON, OP_IE_OFF: begin
                    if (!sup) begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_CTRL;
                    end else begin
                        d.ie_set = (kind == OP_IE_ON);
                        d.ie_clr = (kind == OP_IE_OFF);
                    end
                end
                default: begin
                    d.is_write = (kind == OP_WR);
                    if (space_io) begin
                        if (!sup) begin
                            d.fault = 1'b1;
                            d.cause = CAUSE_IO;
                        end else begin
                            d.tgt = TGT_IO;
                        end
                    end else if (addr_hi) begin
                        d.tgt = TGT_COPROC;
                    end else if (!sup) begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_CTRL;
                    end else begin
                        d.tgt = TGT_CREG;
                    end
                end
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import crau_pkg::*;
(
    input  logic     valid,
    input  op_kind_e kind,
    input  logic     space_io,
    input  logic     addr_hi,
    input  logic     sup,
    output decode_t  dec
);
    always_comb begin
        dec = classify(valid, kind, space_io, addr_hi, sup);
    end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 64,
    parameter logic [ADDR_W-1:0] IE_ADDR   = 16'h0000,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              sys_enter,
    output logic              ie_q,
    output logic              sup_q,
    output logic [DATA_W-1:0] rdata
);
    logic hit_ie;
    logic hit_mode;

    assign hit_ie   = (addr == IE_ADDR);
    assign hit_mode = (addr == MODE_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q  <= 1'b0;
            sup_q <= 1'b1;
        end else begin
            if (ie_set)
                ie_q <= 1'b1;
            else if (ie_clr)
                ie_q <= 1'b0;
            else if (wr_en && hit_ie)
                ie_q <= wbit;

            if (sys_enter)
                sup_q <= 1'b1;
            else if (wr_en && hit_mode)
                sup_q <= wbit;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ie)
            rdata[0] = ie_q;
        else if (hit_mode)
            rdata[0] = sup_q;
    end
endmodule

// File: rtl/ctlreg_resp.sv
module ctlreg_resp
    import crau_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  decode_t           dec,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] creg_rdata,
    input  logic [DATA_W-1:0] cp_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              exc_valid,
    output logic [1:0]        exc_cause,
    output logic              cp_valid,
    output logic              cp_write,
    output logic [ADDR_W-2:0] cp_addr,
    output logic [DATA_W-1:0] cp_wdata,
    output logic              io_valid,
    output logic              io_write,
    output logic [ADDR_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata
);
    logic [DATA_W-1:0] rd_mux;
    logic              rd_ok;

    assign rd_ok = !dec.fault && !dec.is_write && (dec.tgt != TGT_NONE);

    always_comb begin
        case (dec.tgt)
            TGT_CREG:   rd_mux = creg_rdata;
            TGT_COPROC: rd_mux = cp_rdata;
            TGT_IO:     rd_mux = io_rdata;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            exc_valid <= 1'b0;
            exc_cause <= 2'b00;
            cp_valid  <= 1'b0;
            cp_write  <= 1'b0;
            cp_addr   <= '0;
            cp_wdata  <= '0;
            io_valid  <= 1'b0;
            io_write  <= 1'b0;
            io_addr   <= '0;
            io_wdata  <= '0;
        end else begin
            rd_valid  <= rd_ok;
            rd_data   <= rd_ok ? rd_mux : '0;
            exc_valid <= dec.fault;
            exc_cause <= dec.cause;
            cp_valid  <= (dec.tgt == TGT_COPROC);
            cp_write  <= dec.is_write;
            cp_addr   <= addr[ADDR_W-2:0];
            cp_wdata  <= wdata;
            io_valid  <= (dec.tgt == TGT_IO);
            io_write  <= dec.is_write;
            io_addr   <= addr;
            io_wdata  <= wdata;
        end
    end
endmodule

// File: rtl/ctlreg_access_unit.sv
module ctlreg_access_unit
    import crau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic              op_space,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic              sys_enter,
    input  logic [DATA_W-1:0] cp_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              exc_valid,
    output logic [1:0]        exc_cause,
    output logic              cp_valid,
    output logic              cp_write,
    output logic [ADDR_W-2:0] cp_addr,
    output logic [DATA_W-1:0] cp_wdata,
    output logic              io_valid,
    output logic              io_write,
    output logic [ADDR_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata,
    output logic              int_en,
    output logic              sup_mode
);
    decode_t           dec;
    logic [DATA_W-1:0] creg_rdata;
    logic              creg_wr;

    ctlreg_decode u_dec (
        .valid    (op_valid),
        .kind     (op_kind_e'(op_kind)),
        .space_io (op_space),
        .addr_hi  (op_addr[ADDR_W-1]),
        .sup      (sup_mode),
        .dec      (dec)
    );

    assign creg_wr = (dec.tgt == TGT_CREG) && dec.is_write;

    ctlreg_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (creg_wr),
        .addr      (op_addr),
        .wbit      (op_wdata[0]),
        .ie_set    (dec.ie_set),
        .ie_clr    (dec.ie_clr),
        .sys_enter (sys_enter),
        .ie_q      (int_en),
        .sup_q     (sup_mode),
        .rdata     (creg_rdata)
    );

    ctlreg_resp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_resp (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .addr       (op_addr),
        .wdata      (op_wdata),
        .creg_rdata (creg_rdata),
        .cp_rdata   (cp_rdata),
        .io_rdata   (io_rdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .exc_valid  (exc_valid),
        .exc_cause  (exc_cause),
        .cp_valid   (cp_valid),
        .cp_write   (cp_write),
        .cp_addr    (cp_addr),
        .cp_wdata   (cp_wdata),
        .io_valid   (io_valid),
        .io_write   (io_write),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata)
    );
endmodule

// File: rtl/ctlreg_access_unit_chk.sv
module ctlreg_access_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [1:0]  op_kind,
    input logic        op_space,
    input logic [15:0] op_addr,
    input logic [63:0] op_wdata,
    input logic        sys_enter,
    input logic        rd_valid,
    input logic        exc_valid,
    input logic [1:0]  exc_cause,
    input logic        cp_valid,
    input logic        io_valid,
    input logic        int_en,
    input logic        sup_mode
);
    logic user_creg;
    assign user_creg = op_valid && !sup_mode && !op_space && !op_addr[15] && !op_kind[1];

    // R1: at most one kind of response per cycle
    p_one_resp_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_valid, cp_valid, io_valid}));

    // R2: coprocessor strobe only follows an upper-half coprocessor request
    p_cp_source_r2: assert property (@(posedge clk) disable iff (rst)
        cp_valid |-> $past(op_valid && !op_space && op_addr[15] && !op_kind[1]));

    // R3: supervisor write to the enable register takes effect after one edge
    p_ie_write_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && sup_mode && op_kind == 2'd1 && !op_space && op_addr == 16'h0000)
        |=> (int_en == $past(op_wdata[0])));

    // R4: user control-register access traps with the control cause
    p_user_trap_r4: assert property (@(posedge clk) disable iff (rst)
        user_creg |=> (exc_valid && exc_cause == 2'b01 && !rd_valid));

    // R4: the trapped access leaves the interrupt enable untouched
    p_user_keep_r4: assert property (@(posedge clk) disable iff (rst)
        user_creg |=> $stable(int_en));

    // R5: user I/O access traps with the I/O cause
    p_io_trap_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sup_mode && op_space && !op_kind[1])
        |=> (exc_valid && exc_cause == 2'b10 && !io_valid));

    // R8: system entry always restores supervisor mode
    p_sys_enter_r8: assert property (@(posedge clk) disable iff (rst)
        sys_enter |=> sup_mode);
endmodule

bind ctlreg_access_unit ctlreg_access_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .op_space  (op_space),
    .op_addr   (op_addr),
    .op_wdata  (op_wdata),
    .sys_enter (sys_enter),
    .rd_valid  (rd_valid),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .cp_valid  (cp_valid),
    .io_valid  (io_valid),
    .int_en    (int_en),
    .sup_mode  (sup_mode)
);

// File: tb/tb_ctlreg_access_unit.sv
module tb_ctlreg_access_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic        op_space;
    logic [15:0] op_addr;
    logic [63:0] op_wdata;
    logic        sys_enter;
    logic [63:0] cp_rdata;
    logic [63:0] io_rdata;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        exc_valid;
    logic [1:0]  exc_cause;
    logic        cp_valid;
    logic        cp_write;
    logic [14:0] cp_addr;
    logic [63:0] cp_wdata;
    logic        io_valid;
    logic        io_write;
    logic [15:0] io_addr;
    logic [63:0] io_wdata;
    logic        int_en;
    logic        sup_mode;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic m_sup, m_ie;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlreg_access_unit dut (.*);

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic sp, input logic [15:0] a,
                        input logic [63:0] w, input logic se, input string tag);
        logic e_rv, e_exc, e_cpv, e_iov, e_wr, n_sup, n_ie;
        logic [1:0]  e_cause;
        logic [63:0] e_rd;
        op_valid = v; op_kind = k; op_space = sp; op_addr = a; op_wdata = w; sys_enter = se;
        cp_rdata = {w[31:0], 16'hC0DE, a};
        io_rdata = ~cp_rdata;
        @(posedge clk);
        e_rv = 0; e_exc = 0; e_cpv = 0; e_iov = 0; e_cause = 0; e_rd = 0;
        e_wr = (k == 2'd1);
        n_sup = m_sup; n_ie = m_ie;
        if (v) begin
            if (k >= 2'd2) begin
                if (!m_sup) begin e_exc = 1; e_cause = 2'b01; end
                else n_ie = (k == 2'd2);
            end else if (sp) begin
                if (!m_sup) begin e_exc = 1; e_cause = 2'b10; end
                else begin e_iov = 1; e_rv = !e_wr; e_rd = io_rdata; end
            end else if (a >= 16'h8000) begin
                e_cpv = 1; e_rv = !e_wr; e_rd = cp_rdata;
            end else if (!m_sup) begin
                e_exc = 1; e_cause = 2'b01;
            end else if (e_wr) begin
                if (a == 16'h0000) n_ie = w[0];
                if (a == 16'h0001) n_sup = w[0];
            end else begin
                e_rv = 1;
                e_rd = (a == 16'h0000) ? {63'd0, m_ie} : (a == 16'h0001) ? {63'd0, m_sup} : 64'd0;
            end
        end
        if (se) n_sup = 1'b1;
        m_sup = n_sup; m_ie = n_ie;
        @(negedge clk);
        chk(tag, "sup_mode", {63'd0, sup_mode}, {63'd0, m_sup});
        chk(tag, "int_en", {63'd0, int_en}, {63'd0, m_ie});
        chk(tag, "rd_valid", {63'd0, rd_valid}, {63'd0, e_rv});
        chk(tag, "exc_valid", {63'd0, exc_valid}, {63'd0, e_exc});
        chk(tag, "cp_valid", {63'd0, cp_valid}, {63'd0, e_cpv});
        chk(tag, "io_valid", {63'd0, io_valid}, {63'd0, e_iov});
        if (e_rv && rd_valid) chk(tag, "rd_data", rd_data, e_rd);
        if (e_exc && exc_valid) chk(tag, "exc_cause", {62'd0, exc_cause}, {62'd0, e_cause});
        if (e_cpv && cp_valid) begin
            chk(tag, "cp_addr", {49'd0, cp_addr}, {49'd0, a[14:0]});
            chk(tag, "cp_write", {63'd0, cp_write}, {63'd0, e_wr});
            chk(tag, "cp_wdata", cp_wdata, w);
        end
        if (e_iov && io_valid) begin
            chk(tag, "io_addr", {48'd0, io_addr}, {48'd0, a});
            chk(tag, "io_write", {63'd0, io_write}, {63'd0, e_wr});
            chk(tag, "io_wdata", io_wdata, w);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst = 1; op_valid = 0; op_kind = 0; op_space = 0; op_addr = 0; op_wdata = 0;
        sys_enter = 0; cp_rdata = 0; io_rdata = 0;
        m_sup = 1; m_ie = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "sup_mode", {63'd0, sup_mode}, 64'd1);
        chk("R1", "int_en", {63'd0, int_en}, 64'd0);
        chk("R1", "rd_valid", {63'd0, rd_valid}, 64'd0);
        chk("R1", "exc_valid", {63'd0, exc_valid}, 64'd0);
        chk("R1", "strobes", {62'd0, cp_valid, io_valid}, 64'd0);
        rst = 0;

        step(1, 2'd1, 0, 16'h0000, 64'h1, 0, "R3 write ie");
        step(1, 2'd0, 0, 16'h0000, 64'h0, 0, "R3 read ie");
        step(1, 2'd0, 0, 16'h0001, 64'h0, 0, "R3 read mode");
        step(1, 2'd0, 0, 16'h1234, 64'h0, 0, "R7 read unimpl");
        step(1, 2'd1, 0, 16'h7FFF, 64'hFFFF, 0, "R7 write unimpl");
        step(1, 2'd0, 0, 16'h0000, 64'h0, 0, "R7 ie kept");
        step(1, 2'd1, 0, 16'h8005, 64'hDEAD_BEEF_0123_4567, 0, "R2 cp write");
        step(1, 2'd0, 0, 16'hFFFF, 64'h55AA, 0, "R9 cp read");
        step(1, 2'd1, 1, 16'h0042, 64'h0BAD_F00D, 0, "R5 io write");
        step(1, 2'd0, 1, 16'hABCD, 64'h77, 0, "R9 io read");
        step(1, 2'd3, 0, 16'h0000, 64'h0, 0, "R6 ie off");
        step(1, 2'd2, 0, 16'h0000, 64'h0, 0, "R6 ie on");
        step(1, 2'd1, 0, 16'h0001, 64'h0, 0, "R3 drop to user");
        step(1, 2'd0, 0, 16'h0000, 64'h0, 0, "R4 user read cr");
        step(1, 2'd1, 0, 16'h0000, 64'h0, 0, "R4 user write cr");
        step(1, 2'd1, 0, 16'h7FFF, 64'h1, 0, "R4 user boundary");
        step(1, 2'd3, 0, 16'h0000, 64'h0, 0, "R6 user ie off");
        step(1, 2'd0, 1, 16'h0010, 64'h0, 0, "R5 user io");
        step(1, 2'd1, 0, 16'h8000, 64'h1234, 0, "R2 user cp boundary");
        step(0, 2'd0, 0, 16'h0000, 64'h0, 1, "R8 sys enter");
        step(1, 2'd1, 0, 16'h0001, 64'h0, 1, "R8 sys vs write");
        step(1, 2'd0, 0, 16'h0001, 64'h0, 0, "R8 mode readback");

        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[5:4])
                2'd0: a = 16'h0000;
                2'd1: a = 16'h0001;
                2'd2: a = lfsr[6] ? 16'h7FFF : 16'h8000;
                default: a = lfsr[27:12];
            endcase
            step(lfsr[7] | lfsr[8], lfsr[1:0], lfsr[9] & lfsr[10], a,
                 {lfsr, ~lfsr}, (lfsr[15:11] == 5'd3), "R9 mix");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule